// File: doc/BRIEF.md
# Reloading Timer/Event Counter with Frequency-Divider Output

This block is an up-counting timer/event counter with a preload register. It counts prescaled system-clock ticks, edges on an external input, or system-clock ticks that arrive while the external input sits at a chosen level. The counter climbs from the preload value to all ones. The next count is an overflow. On that cycle the counter reloads the preload value, a sticky interrupt flag can be raised, and a divider flip-flop toggles. The divider flip-flop gives a square wave at half the overflow rate.

Software reaches the block through a small register port. It writes the preload value, a control byte, and two port bits: a direction bit and a data bit. The square wave reaches the shared pin only when all three of these hold: the divider is enabled, the pin is an output, and the data bit is 1. Otherwise the pin acts as an ordinary output bit, or it is left undriven.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter, the preload register, the control byte, both port bits and the interrupt flag all read 0, `irq` is 0, `pfd_oe` is 0 and `pfd_pin` is 0.
- R2: The register map is as follows. Address 0 writes the preload register and reads the live counter. Address 1 holds the control byte, with prescale select in bits [2:0], mode in bits [4:3] (0 off, 1 timer, 2 event, 3 pulse-width), level/edge select in bit 5, divider enable in bit 6 and interrupt enable in bit 7. Address 2 holds the direction bit (bit 0, 1 = output) and the data bit (bit 1). Address 3 reads the interrupt flag in bit 0. In mode 0 the counter follows the preload register.
- R3: In timer mode the counter advances once every 2^N system clocks, where N is the prescale select. The time between overflows is therefore (256 - preload) * 2^N clocks.
- R4: The count step taken from 255 is an overflow, and after it the counter holds the preload value.
- R5: Every overflow toggles the divider flip-flop, so the pin changes level once per overflow period.
- R6: With the divider enabled and the direction set to output, `pfd_pin` equals the flip-flop when the data bit is 1, and it is 0 when the data bit is 0. With the divider disabled, `pfd_pin` follows the data bit. `pfd_oe` equals the direction bit. When `pfd_oe` is 0, `pfd_pin` is 0.
- R7: The interrupt flag is set by an overflow only while interrupt enable is 1. It stays set until any write to address 3 clears it. It drives `irq`.
- R8: In event mode `ext_in` passes through a two-flop synchronizer. The counter advances once per rising edge when select is 0, or once per falling edge when select is 1.
- R9: In pulse-width mode the counter advances on prescaled ticks only while the synchronized `ext_in` is high (select 0) or low (select 1).
- R10: On any cycle in which address 0 is read or written, the counter takes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, 0 when not reading |
| ext_in | input | 1 | External timer input, asynchronous |
| irq | output | 1 | Sticky interrupt request |
| pfd_pin | output | 1 | Shared pin output value |
| pfd_oe | output | 1 | Shared pin output enable |

## Verification
A counter that fails to reload, or a divider flop that misses a toggle, changes the spacing between pin edges within a single overflow period. The measured period then differs from (256 - preload) * 2^N. A wrong prescaler phase or a step that should have been inhibited shows up as an off-by-some value when the counter is read back through address 0, on the very next read. An interrupt flag in the wrong state is visible on `irq` one clock after the overflow, or one clock after the clearing write.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int DATA_W = 8;
  localparam int PSC_W  = 3;
  localparam int PS_W   = (1 << PSC_W) - 1;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TIMER = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_PULSE = 2'd3
  } rtmr_mode_e;

  localparam logic [1:0] ADDR_LOAD = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_PORT = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  typedef struct packed {
    logic             irq_en;
    logic             pfd_en;
    logic             sel;
    rtmr_mode_e       mode;
    logic [PSC_W-1:0] psc;
  } rtmr_ctrl_t;

  // low N bits set: prescaler ticks when these are all ones
  function automatic logic [PS_W-1:0] psc_mask(input logic [PSC_W-1:0] n);
    logic [PS_W:0] one;
    one = (PS_W+1)'(1) << n;
    return PS_W'(one - (PS_W+1)'(1));
  endfunction

  // value on the shared pin
  function automatic logic pin_value(input logic en, input logic dir,
                                     input logic dat, input logic flop);
    if (!dir)     return 1'b0;
    else if (en)  return flop & dat;
    else          return dat;
  endfunction
endpackage

// File: rtl/rtmr_prescale.sv
module rtmr_prescale
  import rtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] ps;
  logic [PS_W-1:0] mask;

  assign mask = psc_mask(sel);
  assign tick = run && ((ps & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ps <= '0;
    else if (!run) ps <= '0;
    else           ps <= ps + 1'b1;
  end
endmodule

// File: rtl/rtmr_sense.sv
module rtmr_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic sel,
  output logic active,
  output logic edge_hit
);
  logic [STAGES:0] sh;
  logic level, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign level    = sh[STAGES-1];
  assign prev     = sh[STAGES];
  assign active   = level ^ sel;
  assign edge_hit = sel ? (prev & ~level) : (level & ~prev);
endmodule

// File: rtl/rtmr_count.sv
module rtmr_count
  import rtmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rtmr_mode_e       mode,
  input  logic             psc_tick,
  input  logic             ext_edge,
  input  logic             ext_active,
  input  logic             hold,
  input  logic [WIDTH-1:0] preload,
  output logic [WIDTH-1:0] cnt,
  output logic             step,
  output logic             ovf
);
  logic inc;

  always_comb begin
    unique case (mode)
      MODE_TIMER: step = psc_tick;
      MODE_EVENT: step = ext_edge;
      MODE_PULSE: step = psc_tick & ext_active;
      default:    step = 1'b0;
    endcase
  end

  assign inc = step & ~hold;
  assign ovf = inc & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (mode == MODE_OFF) cnt <= preload;
    else if (ovf)              cnt <= preload;
    else if (inc)              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtmr_pfd_out.sv
module rtmr_pfd_out
  import rtmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic en,
  input  logic dir,
  input  logic dat,
  output logic flop,
  output logic pin,
  output logic oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flop <= 1'b0;
    else if (ovf) flop <= ~flop;
  end

  assign pin = pin_value(en, dir, dat, flop);
  assign oe  = dir;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtmr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_in,
  output logic              irq,
  output logic              pfd_pin,
  output logic              pfd_oe
);
  rtmr_ctrl_t       ctrl_q;
  logic [WIDTH-1:0] preload_q;
  logic [WIDTH-1:0] cnt;
  logic             dir_q, dat_q, flag_q;
  logic             psc_tick, ext_edge, ext_active;
  logic             step, ovf, hold, wr_load, rd_load, wr_flag, pfd_flop;
  logic             psc_run;

  assign wr_load = wr_en && (addr == ADDR_LOAD);
  assign rd_load = rd_en && (addr == ADDR_LOAD);
  assign wr_flag = wr_en && (addr == ADDR_FLAG);
  assign hold    = wr_load | rd_load;
  assign psc_run = (ctrl_q.mode == MODE_TIMER) || (ctrl_q.mode == MODE_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      ctrl_q    <= '0;
      dir_q     <= 1'b0;
      dat_q     <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        ADDR_LOAD: preload_q <= wdata[WIDTH-1:0];
        ADDR_CTRL: ctrl_q    <= rtmr_ctrl_t'(wdata);
        ADDR_PORT: {dat_q, dir_q} <= wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (ovf && ctrl_q.irq_en) flag_q <= 1'b1;
    else if (wr_flag)             flag_q <= 1'b0;
  end

  assign irq = flag_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        ADDR_LOAD: rdata = DATA_W'(cnt);
        ADDR_CTRL: rdata = ctrl_q;
        ADDR_PORT: rdata = DATA_W'({dat_q, dir_q});
        default:   rdata = DATA_W'(flag_q);
      endcase
    end
  end

  rtmr_prescale u_psc (
    .clk(clk), .rst_n(rst_n), .run(psc_run), .sel(ctrl_q.psc), .tick(psc_tick)
  );

  rtmr_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .pin(ext_in), .sel(ctrl_q.sel),
    .active(ext_active), .edge_hit(ext_edge)
  );

  rtmr_count #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .psc_tick(psc_tick),
    .ext_edge(ext_edge), .ext_active(ext_active), .hold(hold),
    .preload(preload_q), .cnt(cnt), .step(step), .ovf(ovf)
  );

  rtmr_pfd_out u_pfd (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .en(ctrl_q.pfd_en), .dir(dir_q),
    .dat(dat_q), .flop(pfd_flop), .pin(pfd_pin), .oe(pfd_oe)
  );
endmodule

// File: rtl/rtmr_chk.sv
module rtmr_chk
  import rtmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovf,
  input logic             hold,
  input logic             ext_edge,
  input rtmr_mode_e       mode,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] preload,
  input logic             flop,
  input logic             irq,
  input logic             irq_en,
  input logic             pfd_en,
  input logic             dir,
  input logic             dat,
  input logic             pin,
  input logic             oe
);
  // R4: overflow leaves the preload value in the counter
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == $past(preload));
  // R5: divider flop toggles on overflow and holds otherwise
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flop != $past(flop));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(flop));
  // R7: enabled overflow raises the request
  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && irq_en) |=> irq);
  // R10: a register access on the counter blocks a step
  a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && mode != MODE_OFF) |=> $stable(cnt));
  // R8: event mode moves only on a detected edge
  a_r8_event_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EVENT && !ext_edge) |=> $stable(cnt));
  // R6: pin gating
  a_r6_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pfd_en && dir && !dat) |-> (oe && !pin));
  a_r6_input: assert property (@(posedge clk) disable iff (!rst_n)
    !dir |-> (!oe && !pin));
endmodule

bind reload_timer rtmr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf(ovf), .hold(hold), .ext_edge(ext_edge),
  .mode(ctrl_q.mode), .cnt(cnt), .preload(preload_q), .flop(pfd_flop),
  .irq(irq), .irq_en(ctrl_q.irq_en), .pfd_en(ctrl_q.pfd_en), .dir(dir_q),
  .dat(dat_q), .pin(pfd_pin), .oe(pfd_oe)
);

// File: tb/sim_reload_timer.sv
`timescale 1ns/1ps
module sim_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, ext_in = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, pfd_pin, pfd_oe;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  reload_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_in(ext_in), .irq(irq),
    .pfd_pin(pfd_pin), .pfd_oe(pfd_oe)
  );

  localparam logic [1:0] OFF = 2'd0, TMR = 2'd1, EVT = 2'd2, PWM = 2'd3;

  function automatic logic [7:0] cb(logic ie, logic pe, logic sel,
                                    logic [1:0] m, logic [2:0] p);
    return {ie, pe, sel, m, p};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_edge();
    logic last;
    int n;
    last = pfd_pin; n = 0;
    while (pfd_pin == last && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic period(output int cyc);
    logic last;
    @(negedge clk);
    wait_edge();
    last = pfd_pin; cyc = 0;
    while (pfd_pin == last && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 counter", d, 0);
    rd(2'd1, d); chk("R1 control", d, 0);
    rd(2'd2, d); chk("R1 port", d, 0);
    chk("R1 irq/oe/pin", {irq, pfd_oe, pfd_pin}, 0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(2'd0, 8'hF0); idle(2);
    rd(2'd0, d); chk("R2 off mode follows preload", d, 8'hF0);
    wr(2'd2, 8'h03);
    rd(2'd2, d); chk("R2 port readback", d, 3);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, OFF, 3'd5));
    rd(2'd1, d); chk("R2 control readback", d, cb(1'b0, 1'b1, 1'b0, OFF, 3'd5));
  endtask

  task automatic t_timer();
    int c;
    wr(2'd0, 8'hFC); idle(2);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, TMR, 3'd0));
    period(c); chk("R3 R5 period psc0 preload FC", c, 4);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, OFF, 3'd0));
    wr(2'd0, 8'hF8); idle(2);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, TMR, 3'd2));
    period(c); chk("R3 R5 period psc2 preload F8", c, 32);
  endtask

  task automatic t_reload();
    logic [7:0] d;
    wait_edge();
    rd(2'd0, d); chk("R4 counter after overflow", d, 8'hF8);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, OFF, 3'd0));
    wr(2'd0, 8'hFE); idle(2);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, TMR, 3'd3));
    begin int c; period(c); chk("R3 period psc3 preload FE", c, 16); end
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(2'd0, 8'hFC);
    wr(2'd1, cb(1'b1, 1'b1, 1'b0, TMR, 3'd0));
    idle(10);
    chk("R7 irq set by overflow", irq, 1);
    rd(2'd3, d); chk("R7 flag readback", d, 1);
    wr(2'd1, cb(1'b1, 1'b1, 1'b0, OFF, 3'd0));
    wr(2'd3, 8'h00); idle(1);
    chk("R7 irq cleared by write", irq, 0);
    wr(2'd1, cb(1'b0, 1'b1, 1'b0, TMR, 3'd0));
    idle(20);
    chk("R7 irq stays low when disabled", irq, 0);
  endtask

  task automatic t_pin();
    logic bad;
    wr(2'd2, 8'h01);
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (pfd_pin !== 1'b0 || pfd_oe !== 1'b1) bad = 1'b1;
    end
    chk("R6 data bit 0 forces low", bad, 0);
    wr(2'd2, 8'h02);
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (pfd_pin !== 1'b0 || pfd_oe !== 1'b0) bad = 1'b1;
    end
    chk("R6 input direction not driven", bad, 0);
    wr(2'd1, cb(1'b0, 1'b0, 1'b0, TMR, 3'd0));
    wr(2'd2, 8'h03);
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); if (pfd_pin !== 1'b1 || pfd_oe !== 1'b1) bad = 1'b1;
    end
    chk("R6 disabled divider plain bit 1", bad, 0);
    wr(2'd2, 8'h01); idle(1);
    chk("R6 disabled divider plain bit 0", {pfd_oe, pfd_pin}, 2'b10);
  endtask

  task automatic pulse();
    @(negedge clk); ext_in = 1'b1; idle(4);
    ext_in = 1'b0; idle(4);
  endtask

  task automatic t_event();
    logic [7:0] d;
    wr(2'd1, cb(1'b1, 1'b0, 1'b0, OFF, 3'd0));
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hFD); idle(3);
    wr(2'd1, cb(1'b1, 1'b0, 1'b0, EVT, 3'd0));
    pulse(); pulse(); idle(2);
    rd(2'd0, d); chk("R8 two rising edges", d, 8'hFF);
    chk("R8 no irq before overflow", irq, 0);
    pulse(); idle(2);
    rd(2'd0, d); chk("R8 R4 third edge reloads", d, 8'hFD);
    chk("R8 R7 irq on event overflow", irq, 1);
    wr(2'd1, cb(1'b0, 1'b0, 1'b1, OFF, 3'd0));
    wr(2'd0, 8'hFE); idle(3);
    wr(2'd1, cb(1'b0, 1'b0, 1'b1, EVT, 3'd0));
    @(negedge clk); ext_in = 1'b1; idle(5);
    rd(2'd0, d); chk("R8 rising ignored with select 1", d, 8'hFE);
    ext_in = 1'b0; idle(5);
    rd(2'd0, d); chk("R8 falling counted with select 1", d, 8'hFF);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    wr(2'd1, cb(1'b0, 1'b0, 1'b0, OFF, 3'd0));
    wr(2'd0, 8'h00); idle(3);
    wr(2'd1, cb(1'b0, 1'b0, 1'b0, PWM, 3'd0));
    idle(3);
    @(negedge clk); ext_in = 1'b1;
    repeat (10) @(negedge clk);
    ext_in = 1'b0; idle(5);
    rd(2'd0, d); chk("R9 high level 10 clocks", d, 10);
    wr(2'd1, cb(1'b0, 1'b0, 1'b1, OFF, 3'd0));
    ext_in = 1'b1;
    wr(2'd0, 8'h00); idle(3);
    wr(2'd1, cb(1'b0, 1'b0, 1'b1, PWM, 3'd0));
    idle(4);
    @(negedge clk); ext_in = 1'b0;
    repeat (6) @(negedge clk);
    ext_in = 1'b1; idle(5);
    rd(2'd0, d); chk("R9 low level 6 clocks", d, 6);
  endtask

  task automatic t_inhibit();
    logic [7:0] v1, v2, v3, v4;
    wr(2'd1, cb(1'b0, 1'b0, 1'b0, OFF, 3'd0));
    wr(2'd0, 8'h00); idle(3);
    wr(2'd1, cb(1'b0, 1'b0, 1'b0, TMR, 3'd0));
    idle(3);
    @(negedge clk); rd_en = 1'b1; addr = 2'd0;
    #1 v1 = rdata;
    @(negedge clk); #1 v2 = rdata;
    chk("R10 read holds counter", v2, v1);
    rd_en = 1'b0; wr_en = 1'b1; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1;
    #1 v3 = rdata;
    chk("R10 preload write holds counter", v3, v1);
    @(negedge clk); rd_en = 1'b0;
    idle(3);
    rd(2'd0, v4);
    chk("R3 R10 free steps resume", v4, 8'(v1 + 8'd4));
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_map();
    t_timer();
    t_reload();
    t_irq();
    t_pin();
    t_event();
    t_pulse();
    t_inhibit();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule